// File: doc/BRIEF.md
# Exclusive Access Monitor

This block is the local monitor that stands between one processor core and its memory port and decides whether a store-exclusive may write. A load-exclusive arms a single reservation and records the data-bus word it touched and the access size. A later store-exclusive to the same word with the same size is let through to memory and reports success. Any other store-exclusive is suppressed and reports failure. Clear-exclusive requests, exception entry and every store-exclusive drop the reservation.

Ordinary loads and stores go straight through to the memory port and leave the reservation alone. All memory-side outputs and the store-exclusive result are registered, so they appear in the cycle after the request. The core issues at most one request strobe per cycle. The exception-entry pulse may arrive in any cycle, including one that also carries a request.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is clear and every output is low, so a store-exclusive issued before any load-exclusive fails.
- R2: A load-exclusive arms the reservation. A following store-exclusive to the same word with the same size then succeeds: one cycle later mem_we_o is 1, sts_fail_o is 0, and mem_addr_o, mem_be_o and mem_wdata_o carry the store's address, lanes and data.
- R3: Addresses are compared at data-bus-word granularity (addr_i[AW-1:2] for a 32-bit bus). A different byte offset inside the reserved word still matches, but a different word fails.
- R4: A store-exclusive whose size code differs from that of the arming load-exclusive fails.
- R5: Every store-exclusive clears the reservation, whether it succeeds or fails. A second store-exclusive right after a successful one fails.
- R6: A clear-exclusive request clears the reservation unconditionally.
- R7: Exception entry clears the reservation. It takes priority over a load-exclusive in the same cycle, and a store-exclusive in the same cycle as exception entry fails.
- R8: A failing store-exclusive performs no memory write (mem_we_o stays 0) and reports sts_fail_o = 1.
- R9: sts_valid_o is 1 in exactly the cycle after each store-exclusive and 0 after any other request or an idle cycle.
- R10: Ordinary loads (mem_re_o = 1 next cycle) and ordinary stores (mem_we_o = 1 next cycle) pass through and do not change the reservation. Load-exclusives also raise mem_re_o.
- R11: Size codes are 0 = byte, 1 = halfword, 2 = word. The byte enables on mem_be_o (bit i = byte lane i) are a single lane at addr_i[1:0], two lanes at the aligned halfword, or all four lanes.
- R12: A new load-exclusive replaces the recorded word and size, so only the most recent one can be matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Ordinary load request |
| st_i | input | 1 | Ordinary store request |
| ldex_i | input | 1 | Load-exclusive request |
| stex_i | input | 1 | Store-exclusive request |
| clrex_i | input | 1 | Clear-exclusive request |
| exc_entry_i | input | 1 | Exception-entry pulse from the core |
| addr_i | input | AW | Byte address of the request |
| size_i | input | 2 | Access size code (0 byte, 1 half, 2 word) |
| wdata_i | input | DW | Store data |
| mem_re_o | output | 1 | Registered read strobe to memory |
| mem_we_o | output | 1 | Registered write enable to memory |
| mem_addr_o | output | AW | Registered address to memory |
| mem_be_o | output | DW/8 | Registered byte-lane enables |
| mem_wdata_o | output | DW | Registered write data |
| sts_valid_o | output | 1 | Store-exclusive result valid |
| sts_fail_o | output | 1 | Store-exclusive result: 0 written, 1 suppressed |

## Verification
Store-exclusives are issued against the reservation in several states. It is tried armed with a matching word and size, armed with a different byte offset in the same word, armed with a different word, armed with a different size, and after reset, clear-exclusive, exception entry and an earlier store-exclusive. These cases separate the word-granular address compare from a byte-exact compare, and show that the size check takes part in the match. Exception entry coinciding with a load-exclusive, and with a store-exclusive, confirms that the exception wins the same-cycle collision. Ordinary loads and stores between an arming load and its store show that pass-through traffic leaves the reservation untouched. Back-to-back load-exclusives show that the newest record replaces the old one.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/excl_lane_dec.sv
module excl_lane_dec
  import excl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OFFW = $clog2(LANES)
) (
  input  acc_size_e         size_i,
  input  logic [OFFW-1:0]   off_i,
  output logic [LANES-1:0]  be_o
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      case (size_i)
        SZ_BYTE: be_o[i] = (off_i == OFFW'(i));
        SZ_HALF: be_o[i] = ((off_i >> 1) == (OFFW'(i) >> 1));
        SZ_WORD: be_o[i] = ((off_i >> 2) == (OFFW'(i) >> 2));
        default: be_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/excl_tag_ctrl.sv
module excl_tag_ctrl
  import excl_pkg::*;
#(
  parameter int WW = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ldex_i,
  input  logic          stex_i,
  input  logic          clrex_i,
  input  logic          exc_i,
  input  logic [WW-1:0] word_i,
  input  acc_size_e     size_i,
  output logic          tag_q,
  output logic          match_o
);
  logic [WW-1:0] rec_word_q;
  acc_size_e     rec_size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q      <= 1'b0;
      rec_word_q <= '0;
      rec_size_q <= SZ_BYTE;
    end else if (exc_i) begin
      tag_q <= 1'b0;
    end else if (ldex_i) begin
      tag_q      <= 1'b1;
      rec_word_q <= word_i;
      rec_size_q <= size_i;
    end else if (stex_i || clrex_i) begin
      tag_q <= 1'b0;
    end
  end

  // The exception pulse forces a same-cycle store-exclusive to fail.
  assign match_o = tag_q && !exc_i && (rec_word_q == word_i) && (rec_size_q == size_i);

  // R7
  exc_clears_tag_chk: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> !tag_q);
  // R5
  stex_clears_tag_chk: assert property (@(posedge clk) disable iff (rst)
    stex_i |=> !tag_q);
  // R6
  clrex_clears_tag_chk: assert property (@(posedge clk) disable iff (rst)
    clrex_i |=> !tag_q);
  // R2
  ldex_arms_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (ldex_i && !exc_i) |=> tag_q);
endmodule

// File: rtl/excl_port_reg.sv
module excl_port_reg
  import excl_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int LANES = DW / 8,
  localparam int OFFW  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic             st_i,
  input  logic             ldex_i,
  input  logic             stex_i,
  input  logic             match_i,
  input  logic [AW-1:0]    addr_i,
  input  acc_size_e        size_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [LANES-1:0] mem_be_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             sts_valid_o,
  output logic             sts_fail_o
);
  logic [LANES-1:0] be_w;
  logic             pass_w, wr_w, rd_w;

  excl_lane_dec #(.LANES(LANES)) u_lane (
    .size_i (size_i),
    .off_i  (addr_i[OFFW-1:0]),
    .be_o   (be_w)
  );

  assign pass_w = stex_i && match_i && (be_w != '0);
  assign wr_w   = st_i || pass_w;
  assign rd_w   = ld_i || ldex_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_re_o    <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      sts_valid_o <= 1'b0;
      sts_fail_o  <= 1'b0;
    end else begin
      mem_re_o    <= rd_w;
      mem_we_o    <= wr_w;
      mem_addr_o  <= addr_i;
      mem_be_o    <= (wr_w || rd_w) ? be_w : '0;
      mem_wdata_o <= wdata_i;
      sts_valid_o <= stex_i;
      sts_fail_o  <= stex_i && !pass_w;
    end
  end

  // R9
  sts_follows_stex_chk: assert property (@(posedge clk) disable iff (rst)
    stex_i |=> sts_valid_o);
  // R9
  no_sts_without_stex_chk: assert property (@(posedge clk) disable iff (rst)
    !stex_i |=> !sts_valid_o);
  // R8
  fail_suppresses_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_valid_o && sts_fail_o) |-> !mem_we_o);
  // R2
  pass_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (sts_valid_o && !sts_fail_o) |-> mem_we_o);
  // R11
  write_has_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_be_o != '0));
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int OFFW  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_i,
  input  logic             st_i,
  input  logic             ldex_i,
  input  logic             stex_i,
  input  logic             clrex_i,
  input  logic             exc_entry_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [LANES-1:0] mem_be_o,
  output logic [DW-1:0]    mem_wdata_o,
  output logic             sts_valid_o,
  output logic             sts_fail_o
);
  acc_size_e size_w;
  logic      tag_w, match_w;

  assign size_w = acc_size_e'(size_i);

  excl_tag_ctrl #(.WW(AW - OFFW)) u_tag (
    .clk     (clk),
    .rst     (rst),
    .ldex_i  (ldex_i),
    .stex_i  (stex_i),
    .clrex_i (clrex_i),
    .exc_i   (exc_entry_i),
    .word_i  (addr_i[AW-1:OFFW]),
    .size_i  (size_w),
    .tag_q   (tag_w),
    .match_o (match_w)
  );

  excl_port_reg #(.AW(AW), .DW(DW)) u_port (
    .clk         (clk),
    .rst         (rst),
    .ld_i        (ld_i),
    .st_i        (st_i),
    .ldex_i      (ldex_i),
    .stex_i      (stex_i),
    .match_i     (match_w),
    .addr_i      (addr_i),
    .size_i      (size_w),
    .wdata_i     (wdata_i),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o),
    .sts_valid_o (sts_valid_o),
    .sts_fail_o  (sts_fail_o)
  );

  // R10
  plain_keeps_tag_chk: assert property (@(posedge clk) disable iff (rst)
    ((ld_i || st_i) && !exc_entry_i) |=> $stable(tag_w));
  // R10
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_i, st_i, ldex_i, stex_i, clrex_i}));
endmodule

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld, st, ldex, stex, clrex, exc;
  logic [31:0] addr, wdata;
  logic [1:0]  size;
  logic        mem_re, mem_we, sts_valid, sts_fail;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  int vecs = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  excl_monitor u_excl_monitor (
    .clk(clk), .rst(rst), .ld_i(ld), .st_i(st), .ldex_i(ldex), .stex_i(stex),
    .clrex_i(clrex), .exc_entry_i(exc), .addr_i(addr), .size_i(size), .wdata_i(wdata),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .sts_valid_o(sts_valid), .sts_fail_o(sts_fail)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {ld, st, ldex, stex, clrex, exc} = '0;
    addr = '0; size = 2'd0; wdata = '0;
  endtask

  // one request per call; returns at the negedge after the capturing posedge
  task automatic drive(input logic l, input logic s, input logic lx, input logic sx,
                       input logic cx, input logic e, input logic [31:0] a,
                       input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    ld = l; st = s; ldex = lx; stex = sx; clrex = cx; exc = e;
    addr = a; size = sz; wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_ldex(input logic [31:0] a, input logic [1:0] sz, input logic e);
    drive(0, 0, 1, 0, 0, e, a, sz, '0);
  endtask

  task automatic do_stex(input string req, input logic [31:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic e, input logic exp_fail,
                         input logic [3:0] exp_be);
    drive(0, 0, 0, 1, 0, e, a, sz, d);
    chk(req, "sts_valid", 32'(sts_valid), 32'd1);
    chk(req, "sts_fail", 32'(sts_fail), 32'(exp_fail));
    chk(req, "mem_we", 32'(mem_we), 32'(!exp_fail));
    if (!exp_fail) begin
      chk(req, "mem_addr", mem_addr, a);
      chk(req, "mem_be", 32'(mem_be), 32'(exp_be));
      chk(req, "mem_wdata", mem_wdata, d);
    end
  endtask

  task automatic t_reset();
    chk("R1", "mem_we", 32'(mem_we), 32'd0);
    chk("R1", "mem_re", 32'(mem_re), 32'd0);
    chk("R1", "sts_valid", 32'(sts_valid), 32'd0);
    chk("R1", "mem_be", 32'(mem_be), 32'd0);
    do_stex("R1", 32'h40, 2'd2, 32'h1111_2222, 0, 1, 4'h0);
  endtask

  task automatic t_basic();
    do_ldex(32'h100, 2'd2, 0);
    chk("R10", "mem_re after ldex", 32'(mem_re), 32'd1);
    chk("R9", "no sts after ldex", 32'(sts_valid), 32'd0);
    do_stex("R2", 32'h100, 2'd2, 32'hCAFE_F00D, 0, 0, 4'hF);
    do_stex("R5", 32'h100, 2'd2, 32'h0BAD_0BAD, 0, 1, 4'h0);
  endtask

  task automatic t_granule();
    do_ldex(32'h201, 2'd0, 0);
    do_stex("R3", 32'h203, 2'd0, 32'hAB00_0000, 0, 0, 4'h8);
    do_ldex(32'h300, 2'd1, 0);
    do_stex("R3", 32'h304, 2'd1, 32'h0000_5555, 0, 1, 4'h0);
    do_ldex(32'h322, 2'd1, 0);
    do_stex("R11", 32'h322, 2'd1, 32'h7777_0000, 0, 0, 4'hC);
  endtask

  task automatic t_size();
    do_ldex(32'h400, 2'd2, 0);
    do_stex("R4", 32'h400, 2'd1, 32'h1234_5678, 0, 1, 4'h0);
  endtask

  task automatic t_clrex();
    do_ldex(32'h500, 2'd2, 0);
    drive(0, 0, 0, 0, 1, 0, 32'h0, 2'd0, '0);
    chk("R9", "no sts after clrex", 32'(sts_valid), 32'd0);
    do_stex("R6", 32'h500, 2'd2, 32'h5A5A_5A5A, 0, 1, 4'h0);
  endtask

  task automatic t_exception();
    do_ldex(32'h600, 2'd2, 0);
    drive(0, 0, 0, 0, 0, 1, 32'h0, 2'd0, '0);
    do_stex("R7", 32'h600, 2'd2, 32'h6666_6666, 0, 1, 4'h0);
    do_ldex(32'h640, 2'd2, 1);
    do_stex("R7", 32'h640, 2'd2, 32'h6464_6464, 0, 1, 4'h0);
    do_ldex(32'h680, 2'd2, 0);
    do_stex("R7", 32'h680, 2'd2, 32'h6868_6868, 1, 1, 4'h0);
  endtask

  task automatic t_passthru();
    do_ldex(32'h700, 2'd2, 0);
    drive(0, 1, 0, 0, 0, 0, 32'h702, 2'd1, 32'hBEEF_0000);
    chk("R10", "st mem_we", 32'(mem_we), 32'd1);
    chk("R11", "st half be", 32'(mem_be), 32'hC);
    chk("R9", "no sts after st", 32'(sts_valid), 32'd0);
    drive(1, 0, 0, 0, 0, 0, 32'h801, 2'd0, '0);
    chk("R10", "ld mem_re", 32'(mem_re), 32'd1);
    chk("R10", "ld mem_we", 32'(mem_we), 32'd0);
    chk("R11", "ld byte be", 32'(mem_be), 32'h2);
    do_stex("R10", 32'h700, 2'd2, 32'h7070_7070, 0, 0, 4'hF);
    @(negedge clk);
    chk("R9", "sts after idle", 32'(sts_valid), 32'd0);
  endtask

  task automatic t_reissue();
    do_ldex(32'h900, 2'd2, 0);
    do_ldex(32'hA00, 2'd2, 0);
    do_stex("R12", 32'h900, 2'd2, 32'h9999_9999, 0, 1, 4'h0);
    do_ldex(32'hB00, 2'd2, 0);
    do_ldex(32'hC00, 2'd0, 0);
    do_stex("R12", 32'hC00, 2'd0, 32'h0000_00CC, 0, 0, 4'h1);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_granule();
    t_size();
    t_clrex();
    t_exception();
    t_passthru();
    t_reissue();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      vecs++;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule